// File: doc/BRIEF.md
# Byte-wide SPI master/slave controller with register access

This block is a serial peripheral interface engine for one byte at a time. A processor reaches it through three 8-bit registers on a simple write-strobe and read-select bus. In master mode a write to the data register starts an 8-bit exchange. The block generates the serial clock by dividing the system clock. It shifts the byte out on the master-out line while it shifts a byte in from the master-in line. In slave mode an external master supplies the serial clock. That clock is brought into the system clock domain and its edges drive the same shift engine.

The control register selects clock polarity, clock phase, bit order, master or slave operation and the clock divider. A select-override bit chooses whether the role comes from the control bit alone or also depends on the select pin. With the override clear, a master whose select pin is pulled low gives up the bus: it drops to slave and raises the completion flag. The status register holds a completion flag and a write-collision flag, and writing 1 to either flag clears it. The interrupt output follows the completion flag when the interrupt-enable input is high.

Top module: `spi_regblk`

## Requirements
- R1: After reset, the control register (reg_sel 0) reads 0x04, the status register (reg_sel 1) reads 0x00, the data register (reg_sel 2) reads 0x00 and irq is low. A value read through rd_data appears one clock after reg_sel is presented. The control bits are: bit 7 select-override, bit 6 enable, bit 5 LSB-first, bit 4 master, bit 3 polarity, bit 2 phase, and bits 1:0 rate.
- R2: In master mode, a write to the data register while no transfer is active starts an 8-bit exchange. When it finishes, the data register reads the byte received on miso_i and status bit 7 is set.
- R3: In master mode, rate codes 0, 1, 2 and 3 give a serial clock of the system clock divided by 4, 16, 64 and 128. That is, 2, 8, 32 and 64 system clocks between successive serial clock edges.
- R4: While no master transfer runs, sck_o rests at the polarity bit. Polarity 0 makes the rising edge the leading edge and polarity 1 makes the falling edge the leading edge. sck_o is back at its rest level after the eighth bit.
- R5: With phase 0, the first bit is on the data line before the first leading edge, later bits change on trailing edges, and inputs are captured on leading edges. With phase 1, bits change on leading edges and are captured on trailing edges.
- R6: With the LSB-first bit set, bit 0 of the byte moves first. With it clear, bit 7 moves first. This applies to both directions and both roles.
- R7: With select-override 0 and master set, driving ss_n_i low clears the master bit (control bit 4 reads 0), sets status bit 7 and releases sck_oe and mosi_oe.
- R8: Status bit 7 is the completion flag and bit 6 is the collision flag. Writing 1 to one of these bits clears only that flag. A flag that is set in the same cycle wins over the clear.
- R9: A write to the data register during a transfer sets status bit 6. The written byte is discarded and the byte being shifted completes unchanged.
- R10: In slave mode, sck_i, mosi_i and ss_n_i pass through a two-stage synchroniser. While the slave is selected (ss_n_i low, or select-override 1), it shifts the data-register byte out on miso_o with miso_oe high. It captures mosi_i into the data register and sets status bit 7 after eight bits.
- R11: irq equals status bit 7 ANDed with irq_en.
- R12: With the enable bit 0, sck_oe, mosi_oe and miso_oe stay low and a data-register write starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data of the register selected one clock earlier |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data in for slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in for master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage synchroniser. The divider is chosen at run time through the rate field, so all four serial clock rates are reached with a single build. The bench measures the spacing of the serial clock edges for each rate. The short synchroniser lets the bench, acting as master, run the slave at twelve system clocks per serial period. Every combination of polarity, phase and bit order can then be exercised in both roles, along with the select-pin takeover and the collision path.

// File: rtl/spi_regblk_pkg.sv
package spi_regblk_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int HALF_W = 7;

  typedef struct packed {
    logic       sel_ovr;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h04;

  // system clocks per serial clock half period
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
    logic [HALF_W-1:0] h;
    if (rate == 2'd3) h = HALF_W'(64);
    else              h = HALF_W'(2) << (2 * rate);
    return h;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= RST_VAL;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sample,
  input  logic         din,
  input  logic         lsb_first,
  output logic         dout,
  output logic [W-1:0] rx_next
);

  logic [W-1:0] tx_sh;
  logic [W-1:0] rx_sh;

  assign dout = lsb_first ? tx_sh[0] : tx_sh[W-1];

  always_comb begin
    rx_next = rx_sh;
    if (sample) begin
      if (lsb_first) rx_next = {din, rx_sh[W-1:1]};
      else           rx_next = {rx_sh[W-2:0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      rx_sh <= rx_next;
      if (load)
        tx_sh <= load_val;
      else if (shift)
        tx_sh <= lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_regblk.sv
module spi_regblk
  import spi_regblk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_en,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);

  localparam int                EDGE_W    = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

  ctrl_t              ctrl;
  logic               spif, wcol;
  logic [DATA_W-1:0]  tx_buf, rx_buf;
  logic               m_busy;
  logic [EDGE_W-1:0]  idx;
  logic               sck_q;
  logic               sck_s_d;

  logic               ss_s, sck_s, mosi_s;
  logic               tick;
  logic               master_mode, fault, slave_act;
  logic               s_edge, m_ev, ev, new_lvl, lead, trail;
  logic               sample, shift, done, busy;
  logic               data_wr, start, load;
  logic [DATA_W-1:0]  load_val, rx_next;
  logic               din, dout;

  spi_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n_i, sck_i, mosi_i}),
    .q   ({ss_s, sck_s, mosi_s})
  );

  spi_clkgen #(.CNT_W(HALF_W)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (m_busy),
    .half (half_period(ctrl.rate)),
    .tick (tick)
  );

  // role selection
  assign master_mode = ctrl.enable & ctrl.master;
  assign fault       = master_mode & ~ctrl.sel_ovr & ~ss_s;
  assign slave_act   = ctrl.enable & ~ctrl.master & (ctrl.sel_ovr | ~ss_s);

  // one edge engine shared by both roles
  assign m_ev    = m_busy & tick;
  assign s_edge  = slave_act & (sck_s != sck_s_d);
  assign ev      = m_ev | s_edge;
  assign new_lvl = m_busy ? ~sck_q : sck_s;
  assign lead    = ev & (new_lvl != ctrl.cpol);
  assign trail   = ev & (new_lvl == ctrl.cpol);
  assign sample  = ctrl.cpha ? trail : lead;
  assign shift   = ctrl.cpha ? (lead && idx != '0) : trail;
  assign done    = trail && (idx == LAST_EDGE);
  assign busy    = m_busy | (slave_act & (idx != '0));

  assign data_wr  = wr_en && (reg_sel == SEL_DATA);
  assign start    = data_wr && !busy && master_mode && !fault;
  assign load     = start | (slave_act && idx == '0 && !ev);
  assign load_val = start ? wr_data : tx_buf;
  assign din      = m_busy ? miso_i : mosi_s;

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (load_val),
    .shift     (shift),
    .sample    (sample),
    .din       (din),
    .lsb_first (ctrl.lsb_first),
    .dout      (dout),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= ctrl_t'(CTRL_RST);
      spif    <= 1'b0;
      wcol    <= 1'b0;
      tx_buf  <= '0;
      rx_buf  <= '0;
      m_busy  <= 1'b0;
      idx     <= '0;
      sck_q   <= CTRL_RST[3];
      sck_s_d <= 1'b0;
      rd_data <= '0;
    end else begin
      sck_s_d <= sck_s;

      if (wr_en && reg_sel == SEL_CTRL)
        ctrl <= ctrl_t'(wr_data[7:0]);

      if (wr_en && reg_sel == SEL_STAT) begin
        if (wr_data[7]) spif <= 1'b0;
        if (wr_data[6]) wcol <= 1'b0;
      end

      if (data_wr) begin
        if (busy) wcol   <= 1'b1;
        else      tx_buf <= wr_data;
      end

      if (!ctrl.enable || fault) begin
        m_busy <= 1'b0;
        idx    <= '0;
      end else if (start) begin
        m_busy <= 1'b1;
        idx    <= '0;
      end else if (ev) begin
        idx <= idx + 1'b1;
        if (done) begin
          m_busy <= 1'b0;
          idx    <= '0;
          spif   <= 1'b1;
          rx_buf <= rx_next;
        end
      end else if (!m_busy && !slave_act) begin
        idx <= '0;
      end

      if (fault) begin
        ctrl.master <= 1'b0;
        spif        <= 1'b1;
      end

      if (m_busy && m_ev && !fault) sck_q <= ~sck_q;
      else if (!m_busy)             sck_q <= ctrl.cpol;

      case (reg_sel)
        SEL_CTRL: rd_data <= DATA_W'(ctrl);
        SEL_STAT: rd_data <= DATA_W'({spif, wcol, 6'b0});
        SEL_DATA: rd_data <= rx_buf;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign irq     = spif & irq_en;
  assign sck_o   = sck_q;
  assign sck_oe  = master_mode;
  assign mosi_o  = dout;
  assign mosi_oe = master_mode;
  assign miso_o  = dout;
  assign miso_oe = slave_act;

endmodule

// File: rtl/spi_regblk_chk.sv
module spi_regblk_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        reg_sel,
  input logic [7:0]        ctrl_q,
  input logic              spif,
  input logic              wcol,
  input logic              m_busy,
  input logic              busy,
  input logic              tick,
  input logic              ss_s,
  input logic [DATA_W-1:0] tx_buf,
  input logic              sck_o
);

  // R9: collision raises the flag
  p_wcol_set_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2 && busy) |=> wcol);

  // R9: colliding byte is dropped
  p_tx_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2 && busy) |=> $stable(tx_buf));

  // R7: select pin takes the bus away from a master
  p_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[6] && ctrl_q[4] && !ctrl_q[7] && !ss_s) |=> (spif && !ctrl_q[4]));

  // R4: serial clock rests at polarity when idle
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!m_busy) |=> (sck_o == $past(ctrl_q[3])));

  // R3: serial clock moves only on divider ticks
  p_sck_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (m_busy && !tick) |=> $stable(sck_o));

  // R2: a master transfer ends with the flag unless disabled
  p_end_flag_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(m_busy) |-> (spif || !ctrl_q[6]));

  // R12: disabled block runs no master transfer
  p_off_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[6]) |=> !m_busy);

endmodule

bind spi_regblk spi_regblk_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .reg_sel (reg_sel),
  .ctrl_q  (8'(ctrl)),
  .spif    (spif),
  .wcol    (wcol),
  .m_busy  (m_busy),
  .busy    (busy),
  .tick    (tick),
  .ss_s    (ss_s),
  .tx_buf  (tx_buf),
  .sck_o   (sck_o)
);

// File: tb/sim_spi_regblk.sv
module sim_spi_regblk;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_en = 1'b0;
  logic       irq;
  logic       sck_i = 1'b0, sck_o, sck_oe;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i = 1'b0, miso_o, miso_oe;
  logic       ss_n_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spi_regblk u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_en(irq_en), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] b, input logic lsbf, input int j);
    return lsbf ? b[j] : b[7-j];
  endfunction

  function automatic int exp_half(input logic [1:0] rate);
    return (rate == 2'd3) ? 64 : (4 << (2 * rate)) / 2;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s;
    @(negedge clk); d = rd_data;
  endtask

  // bench acts as the remote slave while the design is master
  task automatic mxfer(input logic [7:0] tx, input logic [7:0] mi, input logic lsbf,
                       input logic cpol, input logic cpha, input logic [1:0] rate,
                       input logic ovr, input logic collide, input logic clr);
    logic [7:0] got, st, rx;
    logic prev, lead;
    int j, edges, cyc, t1, t2;
    wr(2'd0, {ovr, 1'b1, lsbf, 1'b1, cpol, cpha, rate});
    repeat (2) @(negedge clk);
    chk(sck_o == cpol, "R4 idle level", sck_o, cpol);
    got = 8'h00; j = 0; edges = 0; cyc = 0; t1 = 0; t2 = 0; prev = cpol;
    if (!cpha) miso_i = bit_at(mi, lsbf, 0);
    @(negedge clk); reg_sel = 2'd2; wr_data = tx; wr_en = 1'b1;
    while (edges < 16 && cyc < 5000) begin
      @(negedge clk);
      wr_en = 1'b0;
      cyc++;
      if (sck_o != prev) begin
        prev = sck_o;
        edges++;
        if (edges == 1) t1 = cyc;
        if (edges == 2) t2 = cyc;
        lead = (sck_o != cpol);
        if (lead) begin
          if (!cpha) begin
            if (lsbf) got[j] = mosi_o; else got[7-j] = mosi_o;
          end else begin
            miso_i = bit_at(mi, lsbf, j);
          end
        end else begin
          if (!cpha) begin
            j++;
            if (j < 8) miso_i = bit_at(mi, lsbf, j);
          end else begin
            if (lsbf) got[j] = mosi_o; else got[7-j] = mosi_o;
            j++;
          end
        end
        if (collide && edges == 4) begin
          reg_sel = 2'd2; wr_data = ~tx; wr_en = 1'b1;
        end
      end
    end
    repeat (2) @(negedge clk);
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(t2 - t1 == exp_half(rate), "R3 edge spacing", t2 - t1, exp_half(rate));
    chk(got == tx, "R5 R6 master out byte", got, tx);
    chk(sck_o == cpol, "R4 back to idle", sck_o, cpol);
    chk(irq == irq_en, "R11 irq after done", irq, irq_en);
    rd(2'd1, st);
    chk(st[7] == 1'b1, "R2 completion flag", st, 8'h80);
    if (collide) chk(st[6] == 1'b1, "R9 collision flag", st, 8'hC0);
    rd(2'd2, rx);
    chk(rx == mi, "R2 R5 R6 received byte", rx, mi);
    if (clr) begin
      wr(2'd1, 8'hC0);
      rd(2'd1, st);
      chk(st == 8'h00, "R8 flags cleared", st, 8'h00);
    end
  endtask

  // bench acts as the master while the design is slave
  task automatic sxfer(input logic [7:0] tx, input logic [7:0] mo, input logic lsbf,
                       input logic cpol, input logic cpha, input logic ovr);
    logic [7:0] got, st, rx;
    wr(2'd0, 8'h00);
    sck_i = cpol; ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, {ovr, 1'b1, lsbf, 1'b0, cpol, cpha, 2'b00});
    wr(2'd2, tx);
    if (!ovr) ss_n_i = 1'b0;
    if (!cpha) mosi_i = bit_at(mo, lsbf, 0);
    repeat (6) @(negedge clk);
    chk(miso_oe == 1'b1, "R10 slave drives miso", miso_oe, 1);
    got = 8'h00;
    for (int j = 0; j < 8; j++) begin
      if (!cpha) begin
        if (lsbf) got[j] = miso_o; else got[7-j] = miso_o;
        sck_i = ~cpol;
        repeat (6) @(negedge clk);
        sck_i = cpol;
        if (j < 7) mosi_i = bit_at(mo, lsbf, j + 1);
        repeat (6) @(negedge clk);
      end else begin
        sck_i = ~cpol;
        mosi_i = bit_at(mo, lsbf, j);
        repeat (6) @(negedge clk);
        if (lsbf) got[j] = miso_o; else got[7-j] = miso_o;
        sck_i = cpol;
        repeat (6) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    ss_n_i = 1'b1;
    chk(got == tx, "R10 R6 slave out byte", got, tx);
    rd(2'd2, rx);
    chk(rx == mo, "R10 R5 slave received byte", rx, mo);
    rd(2'd1, st);
    chk(st[7] == 1'b1, "R10 slave completion flag", st, 8'h80);
    wr(2'd1, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R12 outputs released", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(2'd0, v); chk(v == 8'h04, "R1 control reset", v, 8'h04);
    rd(2'd1, v); chk(v == 8'h00, "R1 status reset", v, 8'h00);
    rd(2'd2, v); chk(v == 8'h00, "R1 data reset", v, 8'h00);

    // R12 disabled block ignores a data write
    wr(2'd0, 8'h90);
    wr(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R12 no drive when off", {sck_oe, mosi_oe, miso_oe}, 0);
    rd(2'd1, v); chk(v == 8'h00, "R12 no transfer when off", v, 8'h00);

    // directed master cases over all rates and modes
    mxfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    mxfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    mxfer(8'h0F, 8'hF0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1);
    mxfer(8'hC3, 8'h96, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1);

    // R9 collision, then R8 partial clear
    mxfer(8'h6B, 8'h2D, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk(v == 8'h80, "R8 clear only collision", v, 8'h80);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk(v == 8'h00, "R8 clear completion", v, 8'h00);

    // random master transfers
    for (int i = 0; i < 10; i++) begin
      logic [7:0] t, m;
      t = 8'($urandom); m = 8'($urandom); r = $urandom;
      irq_en = r[6];
      mxfer(t, m, r[0], r[1], r[2], r[4:3], r[5] & ~r[2], 1'b0, 1'b1);
    end
    irq_en = 1'b0;

    // R7 select pin takes over a master
    wr(2'd0, 8'h50);
    repeat (4) @(negedge clk);
    chk(sck_oe == 1'b1, "R7 master drives clock", sck_oe, 1);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk({sck_oe, mosi_oe} == 2'b00, "R7 master released", {sck_oe, mosi_oe}, 0);
    rd(2'd1, v); chk(v[7] == 1'b1, "R7 flag on takeover", v, 8'h80);
    rd(2'd0, v); chk(v[4] == 1'b0, "R7 master bit cleared", v, 8'h40);
    irq_en = 1'b1;
    @(negedge clk); chk(irq == 1'b1, "R11 irq follows flag", irq, 1);
    irq_en = 1'b0;
    @(negedge clk); chk(irq == 1'b0, "R11 irq masked", irq, 0);
    wr(2'd0, 8'h00);
    ss_n_i = 1'b1;
    wr(2'd1, 8'h80);

    // slave cases
    sxfer(8'h5C, 8'hE1, 1'b0, 1'b0, 1'b0, 1'b0);
    sxfer(8'h93, 8'h4A, 1'b1, 1'b1, 1'b1, 1'b0);
    sxfer(8'h27, 8'hB8, 1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] t, m;
      t = 8'($urandom); m = 8'($urandom); r = $urandom;
      sxfer(t, m, r[0], r[1], r[2], 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule